// File: doc/BRIEF.md
# Dual-Target Full-Duplex Serial Shift Port

This block moves one byte at a time between a host and one of two serial targets: a DAC register chain and a front-panel controller. A single shift engine serves both targets. A select input picks the target when a transfer starts. Each target has its own generated serial clock rate. While the host byte leaves on the data-out line, the reply byte arrives on the data-in line under the same clock, so every transfer is an exchange.

The port has three wires per target: clock, data out and data in. Only the target chosen for the current transfer sees clock edges and data. The other target's clock and data-out lines stay at 0. When a DAC exchange ends, the port waits one bit-time and then raises a strobe for one bit-time, so the DAC moves its shifted-in word to its outputs. A front-panel exchange ends without a strobe.

With a 12 MHz system clock, the default dividers of 8 and 128 give 1.5 Mbit/s for the DAC and 93.75 kbit/s for the front panel.

Top module: `duplex_shift_port`

## Requirements
- R1: After reset, `busy`, `done`, `dac_strobe`, both serial clocks and both data-out lines are 0.
- R2: With `target_sel` = 0 (DAC), one bit-time lasts `DAC_DIV` system clocks, so a byte exchange takes `8*DAC_DIV` clocks.
- R3: With `target_sel` = 1 (front panel), one bit-time lasts `FP_DIV` system clocks, so a byte exchange takes `8*FP_DIV` clocks.
- R4: `tx_data` is sent most significant bit first, and data-out changes only when the serial clock falls or when a transfer starts.
- R5: Data-in is sampled on each rising serial clock edge, most significant bit first. After the exchange, `rx_data` holds the byte that the target presented.
- R6: `done` is a pulse one clock wide. It becomes visible 8 bit-times after the clock edge that accepted `start`.
- R7: For DAC transfers only, `dac_strobe` rises one bit-time after the last falling serial clock edge and stays high for exactly one bit-time. A front-panel transfer never raises it.
- R8: The target that was not selected keeps its serial clock and data-out at 0 for the whole transfer.
- R9: While `busy` is high, a change of `target_sel` and any new `start` are ignored. The running transfer completes unchanged.
- R10: `busy` rises on the clock edge that accepts `start` and falls once the last action is over: the final serial clock edge for the front panel, or the end of the strobe for the DAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an exchange (accepted when idle) |
| target_sel | input | 1 | 0 = DAC, 1 = front panel; sampled at start |
| tx_data | input | W | Byte to send, sampled at start |
| rx_data | output | W | Byte received in the last exchange |
| done | output | 1 | One-cycle pulse when rx_data is valid |
| busy | output | 1 | Exchange or strobe in progress |
| dac_sclk | output | 1 | DAC serial clock, idle low |
| dac_sdo | output | 1 | Data to DAC |
| dac_sdi | input | 1 | Data from DAC |
| dac_strobe | output | 1 | DAC output latch pulse |
| fp_sclk | output | 1 | Front-panel serial clock, idle low |
| fp_sdo | output | 1 | Data to front panel |
| fp_sdi | input | 1 | Data from front panel |

## Verification
Every result is timed from the clock edge that accepts `start`. Call it edge 0 and let H be half a bit-time. `done` is due in the cycle after edge 16H. The strobe rises after edge 18H and falls after edge 20H, and `busy` falls at the same point. The bench captures a cycle count at edge 0 and samples on falling clock edges. It compares each measured latency with these exact values, so a result that comes one cycle early or late fails. A model target in the bench shifts its reply on the falling serial clock. It also gathers the bits on data-out and counts the clock edges on both targets.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
   typedef enum logic {
      TGT_DAC = 1'b0,
      TGT_FP  = 1'b1
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2,
      ST_STRB  = 2'd3
   } st_e;

   localparam int unsigned NUM_TGT = 2;
endpackage

// File: rtl/dsp_rate_gen.sv
module dsp_rate_gen #(
   parameter int unsigned HALF_A = 4,
   parameter int unsigned HALF_B = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic sel_b,
   output logic tick
);
   localparam int unsigned MAXH = (HALF_A > HALF_B) ? HALF_A : HALF_B;
   localparam int unsigned CW   = $clog2(MAXH + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   generate
      if (HALF_A == HALF_B) begin : g_single
         assign limit = CW'(HALF_A - 1);
         logic unused_sel;
         assign unused_sel = sel_b;
      end else begin : g_dual
         assign limit = sel_b ? CW'(HALF_B - 1) : CW'(HALF_A - 1);
      end
   endgenerate

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (rst || !run || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt_q <= limit));
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
   import dsp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         sel,
   input  logic [W-1:0] tx_data,
   input  logic         tick,
   input  logic         sdi,
   output logic         sclk,
   output logic         sdo,
   output logic         active,
   output logic         busy,
   output logic         tgt,
   output logic [W-1:0] rx_data,
   output logic         done,
   output logic         strobe
);
   localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;

   st_e          st_q;
   logic [W-1:0] tx_q, rx_q;
   logic [BW-1:0] bcnt_q;
   logic         sclk_q, ph_q, done_q, tgt_q;
   logic         last_fall;

   assign last_fall = (st_q == ST_SHIFT) && tick && sclk_q && (bcnt_q == BW'(W - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         tx_q   <= '0;
         rx_q   <= '0;
         bcnt_q <= '0;
         sclk_q <= 1'b0;
         ph_q   <= 1'b0;
         done_q <= 1'b0;
         tgt_q  <= TGT_DAC;
      end else begin
         done_q <= last_fall;
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_SHIFT;
               tx_q   <= tx_data;
               tgt_q  <= sel;
               bcnt_q <= '0;
               sclk_q <= 1'b0;
            end
            ST_SHIFT: if (tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rx_q   <= {rx_q[W-2:0], sdi};
               end else begin
                  sclk_q <= 1'b0;
                  if (bcnt_q == BW'(W - 1)) begin
                     st_q <= (tgt_q == TGT_DAC) ? ST_GAP : ST_IDLE;
                     ph_q <= 1'b0;
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                     tx_q   <= {tx_q[W-2:0], 1'b0};
                  end
               end
            end
            ST_GAP: if (tick) begin
               ph_q <= ~ph_q;
               if (ph_q) st_q <= ST_STRB;
            end
            ST_STRB: if (tick) begin
               ph_q <= ~ph_q;
               if (ph_q) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk    = sclk_q;
   assign sdo     = tx_q[W-1];
   assign active  = (st_q == ST_SHIFT);
   assign busy    = (st_q != ST_IDLE);
   assign tgt     = tgt_q;
   assign rx_data = rx_q;
   assign done    = done_q;
   assign strobe  = (st_q == ST_STRB);

   p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_SHIFT && $past(st_q) == ST_SHIFT && !$fell(sclk_q)) |-> $stable(tx_q[W-1]));
   p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);
   p_strobe_dac_r7: assert property (@(posedge clk) disable iff (rst)
      strobe |-> (tgt_q == TGT_DAC));
   p_tgt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(tgt_q));
   p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (rst)
      !active |-> !sclk_q);
endmodule

// File: rtl/dsp_router.sv
module dsp_router #(
   parameter int unsigned NT = 2
) (
   input  logic          active,
   input  logic          tgt,
   input  logic          sclk,
   input  logic          sdo,
   output logic [NT-1:0] sclk_o,
   output logic [NT-1:0] sdo_o,
   input  logic [NT-1:0] sdi_i,
   output logic          sdi
);
   generate
      for (genvar t = 0; t < NT; t++) begin : g_lane
         logic hit;
         assign hit       = active && (int'(tgt) == t);
         assign sclk_o[t] = hit & sclk;
         assign sdo_o[t]  = hit & sdo;
      end
   endgenerate

   assign sdi = sdi_i[tgt];
endmodule

// File: rtl/duplex_shift_port.sv
module duplex_shift_port
   import dsp_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter int unsigned DAC_DIV = 8,
   parameter int unsigned FP_DIV  = 128
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         target_sel,
   input  logic [W-1:0] tx_data,
   output logic [W-1:0] rx_data,
   output logic         done,
   output logic         busy,
   output logic         dac_sclk,
   output logic         dac_sdo,
   input  logic         dac_sdi,
   output logic         dac_strobe,
   output logic         fp_sclk,
   output logic         fp_sdo,
   input  logic         fp_sdi
);
   localparam int unsigned DAC_HALF = DAC_DIV / 2;
   localparam int unsigned FP_HALF  = FP_DIV / 2;

   generate
      if (W < 2) begin : g_bad_w
         $error("W must be at least 2");
      end
      if (DAC_DIV < 2 || (DAC_DIV % 2) != 0) begin : g_bad_dac
         $error("DAC_DIV must be even and at least 2");
      end
      if (FP_DIV < 2 || (FP_DIV % 2) != 0) begin : g_bad_fp
         $error("FP_DIV must be even and at least 2");
      end
   endgenerate

   logic tick, sclk, sdo, active, tgt, sdi, strobe;
   logic [NUM_TGT-1:0] sclk_v, sdo_v, sdi_v;

   dsp_rate_gen #(.HALF_A(DAC_HALF), .HALF_B(FP_HALF)) u_rate (
      .clk(clk), .rst(rst), .run(busy), .sel_b(tgt), .tick(tick)
   );

   dsp_shifter #(.W(W)) u_shift (
      .clk(clk), .rst(rst), .start(start), .sel(target_sel), .tx_data(tx_data),
      .tick(tick), .sdi(sdi), .sclk(sclk), .sdo(sdo), .active(active),
      .busy(busy), .tgt(tgt), .rx_data(rx_data), .done(done), .strobe(strobe)
   );

   assign sdi_v[TGT_DAC] = dac_sdi;
   assign sdi_v[TGT_FP]  = fp_sdi;

   dsp_router #(.NT(NUM_TGT)) u_route (
      .active(active), .tgt(tgt), .sclk(sclk), .sdo(sdo),
      .sclk_o(sclk_v), .sdo_o(sdo_v), .sdi_i(sdi_v), .sdi(sdi)
   );

   assign dac_sclk   = sclk_v[TGT_DAC];
   assign dac_sdo    = sdo_v[TGT_DAC];
   assign fp_sclk    = sclk_v[TGT_FP];
   assign fp_sdo     = sdo_v[TGT_FP];
   assign dac_strobe = strobe;

   p_one_clock_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({dac_sclk, fp_sclk}));
   p_quiet_sdo_r8: assert property (@(posedge clk) disable iff (rst)
      !(dac_sdo && fp_sdo));
   p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
      dac_strobe |-> busy);
endmodule

// File: tb/sim_duplex_shift_port.sv
module sim_duplex_shift_port;
   localparam int W = 8;
   localparam int DAC_DIV = 8;
   localparam int FP_DIV = 128;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic target_sel = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic [W-1:0] rx_data;
   logic done, busy, dac_sclk, dac_sdo, dac_strobe, fp_sclk, fp_sdo;
   logic dac_sdi, fp_sdi;

   always #4 clk = ~clk;

   duplex_shift_port #(.W(W), .DAC_DIV(DAC_DIV), .FP_DIV(FP_DIV)) u0 (
      .clk(clk), .rst(rst), .start(start), .target_sel(target_sel), .tx_data(tx_data),
      .rx_data(rx_data), .done(done), .busy(busy),
      .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .dac_sdi(dac_sdi), .dac_strobe(dac_strobe),
      .fp_sclk(fp_sclk), .fp_sdo(fp_sdo), .fp_sdi(fp_sdi)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // target models: reply shifts on falling serial clock, capture on rising
   logic [W-1:0] dac_rep = '0, fp_rep = '0, dac_cap = '0, fp_cap = '0;
   int dac_rises = 0, fp_rises = 0;
   assign dac_sdi = dac_rep[W-1];
   assign fp_sdi  = fp_rep[W-1];
   always @(negedge dac_sclk) dac_rep <= {dac_rep[W-2:0], 1'b0};
   always @(negedge fp_sclk)  fp_rep  <= {fp_rep[W-2:0], 1'b0};
   always @(posedge dac_sclk) begin dac_cap <= {dac_cap[W-2:0], dac_sdo}; dac_rises <= dac_rises + 1; end
   always @(posedge fp_sclk)  begin fp_cap  <= {fp_cap[W-2:0], fp_sdo};   fp_rises  <= fp_rises + 1;  end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      summary();
   end

   // vector: {target, tx byte, reply byte}
   localparam int NV = 6;
   localparam logic [2*W:0] VEC [NV] = '{
      {1'b0, 8'hA5, 8'h3C}, {1'b0, 8'h00, 8'hFF}, {1'b0, 8'hFF, 8'h00},
      {1'b1, 8'h81, 8'h7E}, {1'b1, 8'h5A, 8'hC3}, {1'b0, 8'h01, 8'h80}
   };

   int c0;

   task automatic launch(input logic tg, input logic [W-1:0] tx, input logic [W-1:0] rep);
      @(negedge clk);
      dac_rep = rep; fp_rep = rep;
      dac_rises = 0; fp_rises = 0;
      target_sel = tg; tx_data = tx; start = 1'b1;
      @(posedge clk); #1 c0 = cyc;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R10 busy after start", busy, 1);
   endtask

   task automatic finish_xfer(input logic tg, input logic [W-1:0] tx, input logic [W-1:0] rep);
      int half, lat, w, sawstb;
      half = (tg ? FP_DIV : DAC_DIV) / 2;
      lat = 0;
      for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
      lat = cyc - c0;
      check(lat == 2*W*half, tg ? "R3 FP exchange length" : "R2 DAC exchange length", lat, 2*W*half);
      check(done == 1'b1, "R6 done seen", done, 1);
      check(rx_data == rep, "R5 received byte", rx_data, rep);
      check((tg ? fp_cap : dac_cap) == tx, "R4 MSB-first send", tg ? fp_cap : dac_cap, tx);
      check((tg ? fp_rises : dac_rises) == W, "R8 selected clock edges", tg ? fp_rises : dac_rises, W);
      check((tg ? dac_rises : fp_rises) == 0, "R8 unselected clock quiet", tg ? dac_rises : fp_rises, 0);
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", done, 0);
      if (!tg) begin
         for (int i = 0; i < 4000 && !dac_strobe; i++) @(negedge clk);
         lat = cyc - c0;
         check(lat == (2*W+2)*half, "R7 strobe start", lat, (2*W+2)*half);
         w = 0;
         for (int i = 0; i < 4000 && dac_strobe; i++) begin @(negedge clk); w++; end
         check(w == 2*half, "R7 strobe width", w, 2*half);
         check(busy == 1'b0, "R10 busy ends with strobe", busy, 0);
      end else begin
         check(busy == 1'b0, "R10 busy ends after FP", busy, 0);
         sawstb = 0;
         for (int i = 0; i < 6*half; i++) begin @(negedge clk); if (dac_strobe) sawstb = 1; end
         check(sawstb == 0, "R7 no strobe for FP", sawstb, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({busy, done, dac_strobe, dac_sclk, fp_sclk, dac_sdo, fp_sdo} == '0, "R1 outputs in reset",
            {busy, done, dac_strobe, dac_sclk, fp_sclk, dac_sdo, fp_sdo}, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check({busy, done, dac_strobe, dac_sclk, fp_sclk, dac_sdo, fp_sdo} == '0, "R1 idle after reset",
            {busy, done, dac_strobe, dac_sclk, fp_sclk, dac_sdo, fp_sdo}, 0);

      for (int v = 0; v < NV; v++) begin
         launch(VEC[v][2*W], VEC[v][2*W-1:W], VEC[v][W-1:0]);
         finish_xfer(VEC[v][2*W], VEC[v][2*W-1:W], VEC[v][W-1:0]);
      end

      // R9: select change and second start mid-transfer are ignored
      launch(1'b0, 8'hC6, 8'h1B);
      repeat (20) @(negedge clk);
      target_sel = 1'b1; tx_data = 8'h55; start = 1'b1;
      @(negedge clk); start = 1'b0;
      finish_xfer(1'b0, 8'hC6, 8'h1B);
      check(fp_rises == 0, "R9 late select ignored", fp_rises, 0);

      summary();
   end
endmodule